// File: doc/BRIEF.md
# Power Mode and Heater Controller

This block decides whether the module runs in low-power or high-power mode and drives the module's heaters to match. A low-power request pin sets the mode unless software takes control through a control byte. In that case one software bit chooses the mode and the pin is ignored. In high-power mode a power byte drives three heater outputs: two fixed-wattage spots that are either on or off, and one spot whose duty cycle is set by a 6-bit PWM value.

A signed temperature word is compared against a trip level and a lower release level, which together give hysteresis. While the over-temperature state holds, the PWM spot is held off. Once the temperature has fallen to the release level, the stored duty takes effect again. A two-colour status LED shows the mode as a steady colour, and alternates between its colours while the module is overheated.

Register storage and the temperature sensor sit outside the block. The control byte, the power byte and the temperature word reach it as plain inputs.

Top module: `phc_top`

## Requirements
- R1: With control byte bit 0 (override) clear, `low_power` equals `lpm_pin` (1 = low power), whatever control byte bit 1 holds.
- R2: With control byte bit 0 set, control byte bit 1 picks the mode (1 = low power, 0 = high power) and `lpm_pin` has no effect.
- R3: In high-power mode, `heat_big` follows power byte bit 7 and `heat_mid` follows power byte bit 6.
- R4: In high-power mode, with no over-temperature, `heat_pwm` is high for D of every 64 PWM steps, where D is power byte bits [5:0]. D = 0 keeps it low all the time and D = 63 keeps it high all the time. Each PWM step lasts `PWM_PRESCALE` clock cycles.
- R5: In low-power mode all three heater outputs are low, whatever the power byte holds.
- R6: The temperature word is signed two's complement with 1/256 °C per LSB. A value of 20480 or more sets `over_temp` on the next clock edge. Negative values never set it.
- R7: Once set, `over_temp` stays set while the temperature is above 19200. It clears on the clock edge after the temperature is at or below 19200.
- R8: While `over_temp` is set, `heat_pwm` is low and the static spots keep their R3 behaviour. After release the PWM spot runs at the unchanged duty.
- R9: With `over_temp` clear, the LED is steady: only green in high-power mode, only amber in low-power mode.
- R10: While `over_temp` is set, exactly one LED colour is lit at any time, and the colours swap every `BLINK_DIV` clock cycles.
- R11: After reset `over_temp` is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| lpm_pin | input | 1 | Low-power request pin, 1 = low power |
| ctrl_byte | input | 8 | Bit 0 override enable, bit 1 software mode (1 = low) |
| power_byte | input | 8 | Bits [5:0] PWM duty, bit 6 mid spot, bit 7 big spot |
| temp_word | input | 16 | Signed temperature, 1/256 °C per LSB |
| low_power | output | 1 | Current mode, 1 = low power |
| over_temp | output | 1 | Hysteretic over-temperature state |
| heat_big | output | 1 | Larger static heater enable |
| heat_mid | output | 1 | Smaller static heater enable |
| heat_pwm | output | 1 | PWM heater drive |
| led_green | output | 1 | Green LED drive |
| led_amber | output | 1 | Amber LED drive |

## Verification
The hardest case to reach is a return from the over-temperature state with the PWM duty intact. It needs a temperature that crosses the trip level, then passes through the hysteresis band without releasing, and finally lands exactly on the release level, all while the power byte keeps its value. The stimulus steps the temperature word through 20479, 20480, 19201 and 19200. At each step it checks the cycle on which `over_temp` changes. It also measures the duty over a full PWM period, both while overheated and after release. A negative temperature word whose unsigned value is large is applied as well, to show that the compare is signed.

// File: rtl/phc_pkg.sv
package phc_pkg;
   // control byte fields
   localparam int OVR_BIT  = 0;
   localparam int SET_BIT  = 1;
   // power byte fields
   localparam int MID_BIT  = 6;
   localparam int BIG_BIT  = 7;
   localparam int DUTY_W   = 6;

   typedef struct packed {
      logic green;
      logic amber;
   } led_t;
endpackage

// File: rtl/phc_mode.sv
module phc_mode (
   input  logic pin_req,
   input  logic sw_ovr,
   input  logic sw_set,
   output logic low_power
);
   always_comb begin
      if (sw_ovr) low_power = sw_set;
      else        low_power = pin_req;
   end
endmodule

// File: rtl/phc_thermal.sv
module phc_thermal #(
   parameter int TEMP_W  = 16,
   parameter int TRIP    = 20480,
   parameter int RELEASE = 19200
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [TEMP_W-1:0] temp,
   output logic              hot
);
   localparam logic signed [TEMP_W-1:0] TRIP_V = TEMP_W'(TRIP);
   localparam logic signed [TEMP_W-1:0] REL_V  = TEMP_W'(RELEASE);

   logic signed [TEMP_W-1:0] t_s;
   assign t_s = $signed(temp);

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)             hot <= 1'b0;
      else if (t_s >= TRIP_V) hot <= 1'b1;
      else if (t_s <= REL_V)  hot <= 1'b0;
   end
endmodule

// File: rtl/phc_pwm.sv
module phc_pwm #(
   parameter int CNT_W    = 6,
   parameter int PRESCALE = 4
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [CNT_W-1:0] duty,
   input  logic             enable,
   output logic             pwm_out
);
   logic             tick;
   logic [CNT_W-1:0] step_cnt;

   generate
      if (PRESCALE <= 1) begin : g_noscale
         assign tick = 1'b1;
      end else begin : g_scale
         localparam int PS_W = $clog2(PRESCALE);
         localparam logic [PS_W-1:0] PS_LAST = PS_W'(PRESCALE - 1);
         logic [PS_W-1:0] ps_cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)               ps_cnt <= '0;
            else if (ps_cnt == PS_LAST) ps_cnt <= '0;
            else                      ps_cnt <= ps_cnt + 1'b1;
         end
         assign tick = (ps_cnt == PS_LAST);
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)    step_cnt <= '0;
      else if (tick) step_cnt <= step_cnt + 1'b1;
   end

   assign pwm_out = enable & ((&duty) | (step_cnt < duty));
endmodule

// File: rtl/phc_led.sv
module phc_led
   import phc_pkg::*;
#(
   parameter int BLINK_DIV = 16
) (
   input  logic clk,
   input  logic rst_n,
   input  logic low_power,
   input  logic blink,
   output led_t led
);
   logic phase;

   generate
      if (BLINK_DIV <= 1) begin : g_fast
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) phase <= 1'b0;
            else        phase <= ~phase;
         end
      end else begin : g_div
         localparam int DV_W = $clog2(BLINK_DIV);
         localparam logic [DV_W-1:0] DV_LAST = DV_W'(BLINK_DIV - 1);
         logic [DV_W-1:0] dv_cnt;
         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
               dv_cnt <= '0;
               phase  <= 1'b0;
            end else if (dv_cnt == DV_LAST) begin
               dv_cnt <= '0;
               phase  <= ~phase;
            end else begin
               dv_cnt <= dv_cnt + 1'b1;
            end
         end
      end
   endgenerate

   always_comb begin
      if (blink) begin
         led.green = phase;
         led.amber = ~phase;
      end else begin
         led.green = ~low_power;
         led.amber = low_power;
      end
   end
endmodule

// File: rtl/phc_top.sv
module phc_top
   import phc_pkg::*;
#(
   parameter int TEMP_W       = 16,
   parameter int TRIP_LEVEL   = 20480,
   parameter int RELEASE_LVL  = 19200,
   parameter int PWM_PRESCALE = 4,
   parameter int BLINK_DIV    = 16
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              lpm_pin,
   input  logic [7:0]        ctrl_byte,
   input  logic [7:0]        power_byte,
   input  logic [TEMP_W-1:0] temp_word,
   output logic              low_power,
   output logic              over_temp,
   output logic              heat_big,
   output logic              heat_mid,
   output logic              heat_pwm,
   output logic              led_green,
   output logic              led_amber
);
   generate
      if (RELEASE_LVL >= TRIP_LEVEL) begin : g_bad_hyst
         initial $error("release level must lie below trip level");
      end
      if (TEMP_W < 8) begin : g_bad_width
         initial $error("temperature word too narrow");
      end
   endgenerate

   led_t led_s;
   logic high_pwr;

   phc_mode u_mode (
      .pin_req  (lpm_pin),
      .sw_ovr   (ctrl_byte[OVR_BIT]),
      .sw_set   (ctrl_byte[SET_BIT]),
      .low_power(low_power)
   );

   phc_thermal #(.TEMP_W(TEMP_W), .TRIP(TRIP_LEVEL), .RELEASE(RELEASE_LVL)) u_therm (
      .clk  (clk),
      .rst_n(rst_n),
      .temp (temp_word),
      .hot  (over_temp)
   );

   assign high_pwr = ~low_power;

   phc_pwm #(.CNT_W(DUTY_W), .PRESCALE(PWM_PRESCALE)) u_pwm (
      .clk    (clk),
      .rst_n  (rst_n),
      .duty   (power_byte[DUTY_W-1:0]),
      .enable (high_pwr & ~over_temp),
      .pwm_out(heat_pwm)
   );

   phc_led #(.BLINK_DIV(BLINK_DIV)) u_led (
      .clk      (clk),
      .rst_n    (rst_n),
      .low_power(low_power),
      .blink    (over_temp),
      .led      (led_s)
   );

   assign heat_big  = high_pwr & power_byte[BIG_BIT];
   assign heat_mid  = high_pwr & power_byte[MID_BIT];
   assign led_green = led_s.green;
   assign led_amber = led_s.amber;
endmodule

// File: rtl/phc_checker.sv
module phc_checker #(
   parameter int TEMP_W      = 16,
   parameter int TRIP_LEVEL  = 20480,
   parameter int RELEASE_LVL = 19200
) (
   input logic              clk,
   input logic              rst_n,
   input logic              lpm_pin,
   input logic [7:0]        ctrl_byte,
   input logic [7:0]        power_byte,
   input logic [TEMP_W-1:0] temp_word,
   input logic              low_power,
   input logic              over_temp,
   input logic              heat_big,
   input logic              heat_mid,
   input logic              heat_pwm,
   input logic              led_green,
   input logic              led_amber
);
   localparam logic signed [TEMP_W-1:0] TRIP_V = TEMP_W'(TRIP_LEVEL);
   localparam logic signed [TEMP_W-1:0] REL_V  = TEMP_W'(RELEASE_LVL);

   logic signed [TEMP_W-1:0] t_s;
   assign t_s = $signed(temp_word);

   assert_sw_mode_R2: assert property (@(posedge clk) disable iff (!rst_n)
      ctrl_byte[0] |-> (low_power == ctrl_byte[1]));

   assert_pin_mode_R1: assert property (@(posedge clk) disable iff (!rst_n)
      !ctrl_byte[0] |-> (low_power == lpm_pin));

   assert_lp_quiet_R5: assert property (@(posedge clk) disable iff (!rst_n)
      low_power |-> (!heat_big && !heat_mid && !heat_pwm));

   assert_hot_no_pwm_R8: assert property (@(posedge clk) disable iff (!rst_n)
      over_temp |-> !heat_pwm);

   assert_trip_R6: assert property (@(posedge clk) disable iff (!rst_n)
      (t_s >= TRIP_V) |=> over_temp);

   assert_release_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (t_s <= REL_V) |=> !over_temp);

   assert_band_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
      (t_s > REL_V && t_s < TRIP_V) |=> (over_temp == $past(over_temp)));

   assert_one_colour_R10: assert property (@(posedge clk) disable iff (!rst_n)
      $countones({led_green, led_amber}) == 1);

   assert_full_duty_R4: assert property (@(posedge clk) disable iff (!rst_n)
      (!low_power && !over_temp && (power_byte[5:0] == 6'h3f)) |-> heat_pwm);
endmodule

bind phc_top phc_checker #(
   .TEMP_W(TEMP_W), .TRIP_LEVEL(TRIP_LEVEL), .RELEASE_LVL(RELEASE_LVL)
) u_chk (
   .clk(clk), .rst_n(rst_n), .lpm_pin(lpm_pin), .ctrl_byte(ctrl_byte),
   .power_byte(power_byte), .temp_word(temp_word), .low_power(low_power),
   .over_temp(over_temp), .heat_big(heat_big), .heat_mid(heat_mid),
   .heat_pwm(heat_pwm), .led_green(led_green), .led_amber(led_amber)
);

// File: tb/tb_phc_top.sv
module tb_phc_top;
   localparam int PS  = 4;
   localparam int BD  = 16;
   localparam int PER = 64 * PS;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        lpm_pin = 1'b0;
   logic [7:0]  ctrl_byte = 8'h00;
   logic [7:0]  power_byte = 8'h00;
   logic [15:0] temp_word = 16'd0;
   logic low_power, over_temp, heat_big, heat_mid, heat_pwm, led_green, led_amber;

   int checks = 0;
   int fails  = 0;

   always #10 clk = ~clk;

   phc_top #(.PWM_PRESCALE(PS), .BLINK_DIV(BD)) dut (
      .clk(clk), .rst_n(rst_n), .lpm_pin(lpm_pin), .ctrl_byte(ctrl_byte),
      .power_byte(power_byte), .temp_word(temp_word), .low_power(low_power),
      .over_temp(over_temp), .heat_big(heat_big), .heat_mid(heat_mid),
      .heat_pwm(heat_pwm), .led_green(led_green), .led_amber(led_amber)
   );

   task automatic chk(input logic ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
      end
   endtask

   task automatic settle();
      @(negedge clk);
      #1;
   endtask

   task automatic pwm_high_count(output int n);
      n = 0;
      for (int i = 0; i < PER; i++) begin
         @(negedge clk);
         if (heat_pwm) n++;
      end
   endtask

   task automatic t_reset();
      chk(over_temp == 1'b0, "R11 over_temp in reset", over_temp, 0);
      @(negedge clk); rst_n = 1'b1;
      settle();
      chk(over_temp == 1'b0, "R11 over_temp after reset", over_temp, 0);
      chk(led_green && !led_amber, "R9 led green at start", {led_green, led_amber}, 2);
   endtask

   task automatic t_pin_mode();
      ctrl_byte = 8'h02; lpm_pin = 1'b1; settle();
      chk(low_power == 1'b1, "R1 pin high -> low power", low_power, 1);
      chk(!led_green && led_amber, "R9 led amber in low power", {led_green, led_amber}, 1);
      lpm_pin = 1'b0; settle();
      chk(low_power == 1'b0, "R1 pin low -> high power (set bit ignored)", low_power, 0);
      ctrl_byte = 8'h00;
   endtask

   task automatic t_override();
      ctrl_byte = 8'h03; lpm_pin = 1'b0; settle();
      chk(low_power == 1'b1, "R2 override set=1 pin=0", low_power, 1);
      ctrl_byte = 8'h01; lpm_pin = 1'b1; settle();
      chk(low_power == 1'b0, "R2 override set=0 pin=1", low_power, 0);
      chk(led_green && !led_amber, "R9 led green under override", {led_green, led_amber}, 2);
      ctrl_byte = 8'h00; lpm_pin = 1'b0; settle();
   endtask

   task automatic t_static();
      power_byte = 8'h80; settle();
      chk(heat_big && !heat_mid, "R3 bit7 only", {heat_big, heat_mid}, 2);
      power_byte = 8'h40; settle();
      chk(!heat_big && heat_mid, "R3 bit6 only", {heat_big, heat_mid}, 1);
      power_byte = 8'hC0; settle();
      chk(heat_big && heat_mid, "R3 both spots", {heat_big, heat_mid}, 3);
   endtask

   task automatic t_pwm(input int d);
      int n;
      int exp;
      power_byte = 8'(d); settle();
      pwm_high_count(n);
      exp = (d == 63) ? PER : d * PS;
      chk(n == exp, $sformatf("R4 duty %0d high cycles", d), n, exp);
   endtask

   task automatic t_lowpower();
      int n;
      int stat;
      power_byte = 8'hFF; lpm_pin = 1'b1; settle();
      n = 0; stat = 0;
      for (int i = 0; i < PER; i++) begin
         @(negedge clk);
         if (heat_pwm) n++;
         if (heat_big || heat_mid) stat++;
      end
      chk(n == 0, "R5 pwm off in low power", n, 0);
      chk(stat == 0, "R5 static spots off in low power", stat, 0);
      lpm_pin = 1'b0; settle();
   endtask

   task automatic t_thermal();
      int n;
      int g;
      int bad;
      int sw;
      logic prev;
      power_byte = 8'hFF;
      temp_word = 16'h8000; settle(); settle();
      chk(over_temp == 1'b0, "R6 negative temp no trip", over_temp, 0);
      temp_word = 16'd20479; settle(); settle();
      chk(over_temp == 1'b0, "R6 just below trip", over_temp, 0);
      @(negedge clk); temp_word = 16'd20480; #1;
      chk(over_temp == 1'b0, "R6 not before edge", over_temp, 0);
      settle();
      chk(over_temp == 1'b1, "R6 trip after one edge", over_temp, 1);
      temp_word = 16'd19201;
      pwm_high_count(n);
      chk(n == 0, "R8 pwm off while hot", n, 0);
      chk(over_temp == 1'b1, "R7 held in band", over_temp, 1);
      chk(heat_big && heat_mid, "R8 static spots kept while hot", {heat_big, heat_mid}, 3);
      g = 0; bad = 0; sw = 0; prev = led_green;
      for (int i = 0; i < 4 * BD; i++) begin
         @(negedge clk);
         if (led_green) g++;
         if (led_green == led_amber) bad++;
         if (led_green != prev) sw++;
         prev = led_green;
      end
      chk(bad == 0, "R10 exactly one colour", bad, 0);
      chk(g == 2 * BD, "R10 green half the time", g, 2 * BD);
      chk(sw == 4, "R10 colour swaps", sw, 4);
      @(negedge clk); temp_word = 16'd19200; #1;
      chk(over_temp == 1'b1, "R7 not released before edge", over_temp, 1);
      settle();
      chk(over_temp == 1'b0, "R7 released at 19200", over_temp, 0);
      chk(led_green && !led_amber, "R9 steady green after release", {led_green, led_amber}, 2);
      pwm_high_count(n);
      chk(n == PER, "R8 duty restored after release", n, PER);
   endtask

   initial begin
      #(200000 * 20);
      $display("FAIL watchdog expired actual=hang expected=finish");
      fails++; checks++;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset();
      t_pin_mode();
      t_override();
      t_static();
      t_pwm(0);
      t_pwm(1);
      t_pwm(32);
      t_pwm(62);
      t_pwm(63);
      t_lowpower();
      t_thermal();
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   end
endmodule